// File: doc/BRIEF.md
# Mailbox Command Decoder with One-Shot Microsecond Timer

This block sits behind a mailbox register file. When the register file raises its command strobe, the block captures the first two command words. It splits the first word into three 16-bit fields: a command code, a sequence tag and a set of control flags. The code, tag and flags stay on output ports until the next strobe, so that later response logic can use them. The command code packs a class byte in its upper half and a command byte in its lower half. The classes in use span 0xD1 to 0xD7.

The block reacts to a command in two ways. First, it acknowledges the message when the sender asks for it. Second, it carries out the timer-control command, code 0xD401. The timer is a one-shot that counts in microseconds. A prescaler derives the microsecond tick from the system clock. When the timer runs out, the block asks for an expiry bit to be set in the outbound doorbell.

The block never writes the doorbell itself. Each request is a one-cycle set mask. A neighbouring doorbell register ORs this mask into its contents, so bits that are already set stay set. Any command code the block does not handle raises a one-cycle unsupported-command pulse and has no other effect.

Top module: `mbox_cmd_timer`

## Requirements
- R1: On a cycle with `cmd_strobe_i` high, the block captures word 0 bits [15:0] as the command code, bits [31:16] as the sequence tag and bits [47:32] as the control flags. They appear on the outputs after that clock edge and hold until the next strobe.
- R2: If control-flag bit 9 (value 0x0200) is set, `db_set_o` carries bit 62 for exactly the cycle after the strobe edge, whatever the command code. Bit 62 is doorbell bit 1 counted from the MSB.
- R3: A command without flag 0x0200 produces no bit 62, and a cycle without a strobe or an expiry leaves `db_set_o` at zero.
- R4: Code 0xD401 with flag 0x0001 set and flag 0x0002 clear loads the timer with `cmd_word1_i[DUR_W-1:0]` microseconds. `timer_busy_o` is high from the cycle after the strobe.
- R5: Code 0xD401 with flag 0x0002 stops a running timer. `timer_busy_o` is low from the cycle after the strobe, and no expiry follows.
- R6: With both 0x0001 and 0x0002 set, the start is applied first and the stop second. The net result is an idle timer with no expiry.
- R7: A start while the timer runs reloads it. The expiry then follows the new duration, counted from the new strobe, and the old expiry never happens.
- R8: A start strobed at edge P with duration D expires at edge P + CLKS_PER_US·max(D,1). In the cycle after that edge, `db_set_o` carries bit 49 for one cycle and `timer_busy_o` falls. Bit 49 is doorbell bit 14 counted from the MSB. A duration of zero expires on the first tick.
- R9: Any code other than 0xD401 raises `unsup_o` for the one cycle after the strobe and does not disturb a running timer.
- R10: During and right after reset, every output is zero.
- R11: When an acknowledge and an expiry land in the same cycle, `db_set_o` carries bits 62 and 49 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_strobe_i | input | 1 | One-cycle strobe: a command is present in the words |
| cmd_word0_i | input | 64 | Command word 0 (code, tag, flags) |
| cmd_word1_i | input | 64 | Command word 1 (timer duration in microseconds) |
| cmd_code_o | output | 16 | Captured command code |
| seq_id_o | output | 16 | Captured sequence tag |
| ctrl_flags_o | output | 16 | Captured control flags |
| db_set_o | output | 64 | One-cycle set mask for the outbound doorbell |
| unsup_o | output | 1 | One-cycle pulse for an unsupported command code |
| timer_busy_o | output | 1 | Timer is counting |

## Verification
The bench builds the block with four clocks per microsecond and a 16-bit duration field. This makes every expiry a short, exactly countable number of cycles. As a result, zero and small durations, a reload midway through a count, and a stop before expiry all finish within a few dozen cycles. The short microsecond also makes it easy to place an acknowledging strobe on the very edge where a timer expires, so that the merged doorbell mask is observed directly.

// File: rtl/mbox_cmd_pkg.sv
// Package: constants and the header type shared by the command decoder.
// Assumes 64-bit mailbox words and a 64-bit doorbell numbered LSB = 0.
package mbox_cmd_pkg;
    localparam int WORD_W        = 64;
    localparam int FIELD_W       = 16;
    localparam int DB_W          = 64;
    localparam logic [15:0] CODE_TIMER = 16'hD401;
    localparam int FLG_START_BIT = 0;
    localparam int FLG_STOP_BIT  = 1;
    localparam int FLG_ACK_BIT   = 9;
    // doorbell bits counted from the MSB are mapped to LSB indices
    localparam int DB_MSGREAD_IDX = DB_W - 1 - 1;
    localparam int DB_EXPIRY_IDX  = DB_W - 1 - 14;

    typedef struct packed {
        logic [FIELD_W-1:0] flags;
        logic [FIELD_W-1:0] seq;
        logic [FIELD_W-1:0] code;
    } cmd_hdr_t;
endpackage

// File: rtl/mbox_hdr_latch.sv
// Module: captures the header of word 0 on a strobe and decodes it.
// Produces registered one-cycle acknowledge and unsupported pulses, and
// combinational timer start/stop requests valid in the strobe cycle.
// Assumes the strobe is a single-cycle qualifier for word 0.
module mbox_hdr_latch
    import mbox_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_i,
    input  logic [WORD_W-1:0] word0_i,
    output cmd_hdr_t          hdr_o,
    output logic              ack_pulse_o,
    output logic              unsup_pulse_o,
    output logic              tmr_start_o,
    output logic              tmr_stop_o
);
    cmd_hdr_t hdr_in;
    logic     is_timer;
    logic     unused_hi;

    // Purpose: view the low three fields of word 0 as a header.
    assign hdr_in    = cmd_hdr_t'(word0_i[3*FIELD_W-1:0]);
    assign unused_hi = ^word0_i[WORD_W-1:3*FIELD_W];

    // Purpose: decode the timer command and its start/stop flags.
    always_comb begin
        is_timer    = (hdr_in.code == CODE_TIMER);
        tmr_start_o = strobe_i && is_timer && hdr_in.flags[FLG_START_BIT];
        tmr_stop_o  = strobe_i && is_timer && hdr_in.flags[FLG_STOP_BIT];
    end

    // Purpose: hold the header and emit the per-strobe pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_o         <= '0;
            ack_pulse_o   <= 1'b0;
            unsup_pulse_o <= 1'b0;
        end else begin
            ack_pulse_o   <= strobe_i && hdr_in.flags[FLG_ACK_BIT];
            unsup_pulse_o <= strobe_i && !is_timer;
            if (strobe_i) begin
                hdr_o <= hdr_in;
            end
        end
    end
endmodule

// File: rtl/us_tick_gen.sv
// Module: divides the system clock into a one-microsecond tick.
// The phase restarts on every timer start and is held at zero while idle,
// so the first tick comes exactly CLKS_PER_US edges after a start.
module us_tick_gen #(
    parameter int CLKS_PER_US = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic restart_i,
    output logic tick_o
);
    localparam int PW = (CLKS_PER_US > 1) ? $clog2(CLKS_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLKS_PER_US - 1);

    generate
        if (CLKS_PER_US == 1) begin : g_direct
            // Purpose: every clock is a microsecond; no divider needed.
            assign tick_o = run_i;
        end else begin : g_div
            logic [PW-1:0] phase;

            // Purpose: count clocks within the current microsecond.
            always_ff @(posedge clk) begin
                if (!rst_n || restart_i || !run_i) begin
                    phase <= '0;
                end else if (phase == LAST) begin
                    phase <= '0;
                end else begin
                    phase <= phase + 1'b1;
                end
            end

            assign tick_o = run_i && (phase == LAST);
        end
    endgenerate
endmodule

// File: rtl/oneshot_us_timer.sv
// Module: one-shot down-counter in microseconds.
// A command (start and/or stop) takes priority over a tick in the same
// cycle. Start then stop within one command leaves the timer idle.
// Durations 0 and 1 both expire on the first tick.
module oneshot_us_timer #(
    parameter int DUR_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic [DUR_W-1:0] dur_i,
    input  logic             tick_i,
    output logic             busy_o,
    output logic             expire_o
);
    logic [DUR_W-1:0] remain;

    // Purpose: load, cancel or decrement the count and flag expiry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain   <= '0;
            busy_o   <= 1'b0;
            expire_o <= 1'b0;
        end else begin
            expire_o <= 1'b0;
            if (start_i || stop_i) begin
                if (start_i) begin
                    remain <= dur_i;
                    busy_o <= 1'b1;
                end
                if (stop_i) begin
                    busy_o <= 1'b0;
                end
            end else if (busy_o && tick_i) begin
                if (remain <= DUR_W'(1)) begin
                    busy_o   <= 1'b0;
                    expire_o <= 1'b1;
                end else begin
                    remain <= remain - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/mbox_cmd_timer.sv
// Module: top of the command decoder. Ties header capture, the
// microsecond prescaler and the one-shot timer together, and forms the
// doorbell set mask. Assumes a neighbour ORs db_set_o into its doorbell.
module mbox_cmd_timer
    import mbox_cmd_pkg::*;
#(
    parameter int CLKS_PER_US = 100,
    parameter int DUR_W       = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_strobe_i,
    input  logic [63:0] cmd_word0_i,
    input  logic [63:0] cmd_word1_i,
    output logic [15:0] cmd_code_o,
    output logic [15:0] seq_id_o,
    output logic [15:0] ctrl_flags_o,
    output logic [63:0] db_set_o,
    output logic        unsup_o,
    output logic        timer_busy_o
);
    cmd_hdr_t hdr;
    logic     ack_pulse;
    logic     tmr_start;
    logic     tmr_stop;
    logic     tick;
    logic     expire;

    mbox_hdr_latch u_hdr (
        .clk           (clk),
        .rst_n         (rst_n),
        .strobe_i      (cmd_strobe_i),
        .word0_i       (cmd_word0_i),
        .hdr_o         (hdr),
        .ack_pulse_o   (ack_pulse),
        .unsup_pulse_o (unsup_o),
        .tmr_start_o   (tmr_start),
        .tmr_stop_o    (tmr_stop)
    );

    us_tick_gen #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (timer_busy_o),
        .restart_i (tmr_start),
        .tick_o    (tick)
    );

    oneshot_us_timer #(.DUR_W(DUR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (tmr_start),
        .stop_i   (tmr_stop),
        .dur_i    (cmd_word1_i[DUR_W-1:0]),
        .tick_i   (tick),
        .busy_o   (timer_busy_o),
        .expire_o (expire)
    );

    generate
        if (DUR_W < WORD_W) begin : g_w1_spare
            logic unused_w1;
            assign unused_w1 = ^cmd_word1_i[WORD_W-1:DUR_W];
        end
    endgenerate

    // Purpose: present the held header fields.
    assign cmd_code_o   = hdr.code;
    assign seq_id_o     = hdr.seq;
    assign ctrl_flags_o = hdr.flags;

    // Purpose: merge acknowledge and expiry requests into one set mask.
    always_comb begin
        db_set_o                 = '0;
        db_set_o[DB_MSGREAD_IDX] = ack_pulse;
        db_set_o[DB_EXPIRY_IDX]  = expire;
    end
endmodule

// File: rtl/mbox_cmd_timer_chk.sv
// Checker: temporal properties of the command decoder, bound to the top.
module mbox_cmd_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_strobe_i,
    input logic [63:0] cmd_word0_i,
    input logic [63:0] cmd_word1_i,
    input logic [15:0] cmd_code_o,
    input logic [15:0] seq_id_o,
    input logic [15:0] ctrl_flags_o,
    input logic [63:0] db_set_o,
    input logic        unsup_o,
    input logic        timer_busy_o
);
    logic [63:0] allowed;
    logic        tcmd;
    logic        unused_w1;
    assign allowed   = (64'd1 << 62) | (64'd1 << 49);
    assign tcmd      = cmd_strobe_i && (cmd_word0_i[15:0] == 16'hD401);
    assign unused_w1 = ^cmd_word1_i ^ ^ctrl_flags_o;

    // R1
    hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_strobe_i |=> $stable(cmd_code_o) && $stable(seq_id_o));
    // R2
    ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe_i && cmd_word0_i[41] |=> db_set_o[62]);
    // R3
    ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        db_set_o[62] |-> $past(cmd_strobe_i && cmd_word0_i[41]));
    // R3
    mask_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (db_set_o & ~allowed) == 64'd0);
    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tcmd && cmd_word0_i[32] && !cmd_word0_i[33] |=> timer_busy_o);
    // R5
    stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tcmd && cmd_word0_i[33] |=> !timer_busy_o && !db_set_o[49]);
    // R8
    expiry_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        db_set_o[49] |-> $past(timer_busy_o) && !timer_busy_o);
    // R9
    unsup_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unsup_o |-> $past(cmd_strobe_i) && ($past(cmd_word0_i[15:0]) != 16'hD401));
endmodule

bind mbox_cmd_timer mbox_cmd_timer_chk i_chk (.*);

// File: tb/test_mbox_cmd_timer.sv
module test_mbox_cmd_timer;
    localparam int CLK_PERIOD = 10;
    localparam int US = 4;
    localparam int DW = 16;
    localparam logic [63:0] B_ACK = 64'd1 << 62;
    localparam logic [63:0] B_EXP = 64'd1 << 49;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_strobe_i = 1'b0;
    logic [63:0] cmd_word0_i = '0;
    logic [63:0] cmd_word1_i = '0;
    logic [15:0] cmd_code_o, seq_id_o, ctrl_flags_o;
    logic [63:0] db_set_o;
    logic        unsup_o, timer_busy_o;

    mbox_cmd_timer #(.CLKS_PER_US(US), .DUR_W(DW)) i_mbox_cmd_timer (
        .clk(clk), .rst_n(rst_n), .cmd_strobe_i(cmd_strobe_i),
        .cmd_word0_i(cmd_word0_i), .cmd_word1_i(cmd_word1_i),
        .cmd_code_o(cmd_code_o), .seq_id_o(seq_id_o),
        .ctrl_flags_o(ctrl_flags_o), .db_set_o(db_set_o),
        .unsup_o(unsup_o), .timer_busy_o(timer_busy_o));

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          cyc;
        logic [63:0] mask;
        bit          unsup;
        string       req;
        bit          is_exp;
    } item_t;

    item_t sb[$];
    int    cyc = 0;
    int    nvec = 0;
    int    nfail = 0;
    bit    ended = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        nvec++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: called at a negedge; pushes expectations, pulses the strobe.
    task automatic send(input logic [15:0] code, input logic [15:0] seq,
                        input logic [15:0] flags, input logic [63:0] dur,
                        output int p);
        item_t it;
        p = cyc + 1;
        cmd_strobe_i = 1'b1;
        cmd_word0_i  = {16'h0, flags, seq, code};
        cmd_word1_i  = dur;
        if (flags[9]) begin
            it = '{p, B_ACK, 1'b0, "R2", 1'b0};
            sb.push_back(it);
        end
        if (code != 16'hD401) begin
            it = '{p, 64'd0, 1'b1, "R9", 1'b0};
            sb.push_back(it);
        end else if (flags[0] || flags[1]) begin
            for (int i = sb.size() - 1; i >= 0; i--)
                if (sb[i].is_exp && sb[i].cyc >= p) sb.delete(i);
            if (flags[0] && !flags[1]) begin
                it = '{p + US * ((dur == 0) ? 1 : int'(dur)), B_EXP, 1'b0, "R8", 1'b1};
                sb.push_back(it);
            end
        end
        @(negedge clk);
        cmd_strobe_i = 1'b0;
    endtask

    // Monitor: pops the items due this cycle and compares the pulses.
    always @(negedge clk) begin
        logic [63:0] em;
        bit          eu;
        string       rq;
        if (rst_n && !ended) begin
            em = '0; eu = 0; rq = "";
            for (int i = sb.size() - 1; i >= 0; i--) begin
                if (sb[i].cyc == cyc) begin
                    em |= sb[i].mask; eu |= sb[i].unsup;
                    rq = {rq, " ", sb[i].req};
                    sb.delete(i);
                end else if (sb[i].cyc < cyc) begin
                    check(1'b0, sb[i].req, "missing pulse", 64'd0, sb[i].mask);
                    sb.delete(i);
                end
            end
            if (rq == "") rq = "R3 R5 R9";
            if (em == B_ACK | B_EXP) rq = {rq, " R11"};
            if (em != 0 || eu || db_set_o != 0 || unsup_o) begin
                check(db_set_o == em, rq, "db_set", db_set_o, em);
                check(unsup_o == eu, rq, "unsup", 64'(unsup_o), 64'(eu));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", "timeout", 64'd0, 64'd1);
        finish_run();
    end

    initial begin
        int p, q;
        idle(3);
        // R10: reset state
        check(db_set_o == 0 && !unsup_o && !timer_busy_o, "R10", "pulses",
              {db_set_o[63:2], unsup_o, timer_busy_o}, 64'd0);
        check({cmd_code_o, seq_id_o, ctrl_flags_o} == 0, "R10", "fields",
              64'({cmd_code_o, seq_id_o, ctrl_flags_o}), 64'd0);
        rst_n = 1'b1;
        idle(2);

        // R1 R2 R9: unsupported with acknowledge
        send(16'hD201, 16'h1234, 16'h0200, 64'd0, p);
        check(cmd_code_o == 16'hD201, "R1", "code", 64'(cmd_code_o), 64'hD201);
        check(seq_id_o == 16'h1234, "R1", "seq", 64'(seq_id_o), 64'h1234);
        check(ctrl_flags_o == 16'h0200, "R1", "flags", 64'(ctrl_flags_o), 64'h0200);
        idle(3);
        check(seq_id_o == 16'h1234, "R1", "seq held", 64'(seq_id_o), 64'h1234);

        // R3: no acknowledge requested
        send(16'hD702, 16'h00AA, 16'h0000, 64'd0, p);
        check(seq_id_o == 16'h00AA, "R1", "seq", 64'(seq_id_o), 64'h00AA);
        idle(3);

        // R4 R8: plain start
        send(16'hD401, 16'h0001, 16'h0001, 64'd5, p);
        check(timer_busy_o, "R4", "busy", 64'(timer_busy_o), 64'd1);
        idle(25);
        check(!timer_busy_o, "R8", "busy after expiry", 64'(timer_busy_o), 64'd0);

        // R8 R2: zero duration with acknowledge
        send(16'hD401, 16'h0002, 16'h0201, 64'd0, p);
        idle(8);

        // R5: stop before expiry
        send(16'hD401, 16'h0003, 16'h0001, 64'd10, p);
        idle(8);
        send(16'hD401, 16'h0004, 16'h0002, 64'd0, q);
        check(!timer_busy_o, "R5", "busy after stop", 64'(timer_busy_o), 64'd0);
        idle(50);

        // R6: start and stop together
        send(16'hD401, 16'h0005, 16'h0003, 64'd3, p);
        check(!timer_busy_o, "R6", "busy", 64'(timer_busy_o), 64'd0);
        idle(20);

        // R7: reload while running
        send(16'hD401, 16'h0006, 16'h0001, 64'd10, p);
        idle(12);
        send(16'hD401, 16'h0007, 16'h0001, 64'd2, q);
        check(timer_busy_o, "R7", "busy after reload", 64'(timer_busy_o), 64'd1);
        idle(50);

        // R11: acknowledge lands on the expiry edge
        send(16'hD401, 16'h0008, 16'h0001, 64'd3, p);
        idle(11);
        send(16'hD201, 16'h0009, 16'h0200, 64'd0, q);
        idle(5);

        // R9: unsupported code leaves a running timer alone
        send(16'hD401, 16'h000A, 16'h0001, 64'd5, p);
        idle(3);
        send(16'hD101, 16'h000B, 16'h0000, 64'd0, q);
        check(timer_busy_o, "R9", "busy kept", 64'(timer_busy_o), 64'd1);
        idle(25);

        check(sb.size() == 0, "R8", "items left", 64'(sb.size()), 64'd0);
        finish_run();
    end
endmodule